// File: doc/BRIEF.md
# Debug Data Exchange CSR

This block is a mailbox register that sits in a CPU core's CSR space and carries single data words between the core and an external debug module. The debug module loads a word into the block through its own write port. The core then fetches that word with an ordinary CSR read at the mailbox address. In the other direction, the core writes the mailbox with a CSR write. That write is not stored as readable state. Instead the block hands the word to the debug side as a capture event: a one-cycle valid strobe, plus a captured word that stays put until the debug module clears it.

The block is therefore two registers that share one CSR address. One holds the readable value and is owned by the debug module. The other holds the captured word and is filled by the core. Transporting the words to a debugger, decoding instructions and checking privilege are all handled elsewhere. Apart from the address match, the block makes no access checks.

Top module: `dbgx_mailbox_csr`

## Requirements
- R1: A core read (`csr_valid`=1, `csr_write`=0) at address `MAILBOX_ADDR` (default 12'h7B4) loads `csr_rdata`, at that clock edge, with the readable value as it stood before the edge.
- R2: When `dm_wr_en` is 1, the readable value takes `dm_wr_data` at the clock edge. The new value is returned by any core read in a later cycle.
- R3: A core write (`csr_valid`=1, `csr_write`=1) at `MAILBOX_ADDR` drives `dm_data_valid` high for exactly the one cycle after the edge. In that cycle `dm_data` equals the written `csr_wdata`.
- R4: A core write at `MAILBOX_ADDR` never alters the readable value. A later core read returns the last word supplied by the debug module.
- R5: If a debug-module write and a core write fall in the same cycle, the readable value takes `dm_wr_data`, and the core word is still captured with the strobe.
- R6: `dm_clear` zeroes `dm_data` without raising `dm_data_valid`. If it coincides with a core write at the mailbox address, the core word is captured instead.
- R7: Between captures and clears, `dm_data` holds its last captured word.
- R8: An access at any other address, or a cycle with `csr_valid`=0, leaves `csr_rdata`, `dm_data` and `dm_data_valid` as they were, and `dm_data_valid` stays 0.
- R9: A synchronous reset (`rst_n`=0) sets the readable value, `csr_rdata` and `dm_data` to zero and drops `dm_data_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_valid | input | 1 | Core CSR access this cycle |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_addr | input | ADDR_W (12) | Core CSR address |
| csr_wdata | input | DATA_W (32) | Core write data |
| csr_rdata | output | DATA_W (32) | Registered read result |
| dm_wr_en | input | 1 | Debug module loads the readable value |
| dm_wr_data | input | DATA_W (32) | Word loaded by the debug module |
| dm_clear | input | 1 | Debug module discards the captured word |
| dm_data_valid | output | 1 | One-cycle strobe for a captured core write |
| dm_data | output | DATA_W (32) | Last captured core word |

## Verification
The bench sweeps the whole 12-bit address space with reads and then with writes, each carrying a data word derived from the address. This separates a correct full-width address match from a partial decode: any alias would strobe or overwrite the read result at the wrong address. The bench then runs debug loads followed by core reads, core writes followed by reads, and same-cycle collisions of debug load with core write and of clear with core write. These patterns show that the readable and captured paths are independent, and they pin down which side wins in each collision. Back-to-back core writes and idle gaps show that the strobe lasts exactly one cycle per write and that the captured word holds between captures.

// File: rtl/dbgx_pkg.sv
// Package: shared definitions for the debug mailbox CSR.
// Assumes a 12-bit CSR address space and one decoded access per cycle.
package dbgx_pkg;
    // Kind of access decoded against the mailbox address.
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/dbgx_addr_match.sv
// Module: decodes a core CSR access against one fixed address.
// Assumes that the access fields are valid only while req_valid is high.
module dbgx_addr_match #(
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] MATCH_ADDR = 12'h7B4
) (
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    output dbgx_pkg::acc_kind_e  kind
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(MATCH_ADDR);

    // Classify the access as none, read hit or write hit.
    always_comb begin
        kind = dbgx_pkg::ACC_NONE;
        if (req_valid && (req_addr == MATCH)) begin
            kind = req_write ? dbgx_pkg::ACC_WRITE : dbgx_pkg::ACC_READ;
        end
    end
endmodule

// File: rtl/dbgx_value_reg.sv
// Module: holds the readable value, which is owned by the debug module,
// and the registered read result. Assumes that core writes never reach
// this module, so its value changes only through the debug-side load.
module dbgx_value_reg #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic [DATA_W-1:0]   load_data,
    input  logic                read_hit,
    output logic [DATA_W-1:0]   rdata
);
    logic [DATA_W-1:0] value_q;

    // Readable value: loaded only by the debug module.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (load_en) begin
            value_q <= load_data;
        end
    end

    // Read result: updated only on a mailbox read, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (read_hit) begin
            rdata <= value_q;
        end
    end
endmodule

// File: rtl/dbgx_capture.sv
// Module: turns a core write into a one-cycle strobe and keeps the word
// until the debug side clears it. Assumes write_hit is at most one per
// cycle. A write wins over a clear in the same cycle.
module dbgx_capture #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                write_hit,
    input  logic [DATA_W-1:0]   write_data,
    input  logic                clear,
    output logic                strobe,
    output logic [DATA_W-1:0]   word
);
    // Strobe: high for the one cycle after each captured write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0;
        end else begin
            strobe <= write_hit;
        end
    end

    // Captured word: take the new write, else clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (write_hit) begin
            word <= write_data;
        end else if (clear) begin
            word <= '0;
        end
    end
endmodule

// File: rtl/dbgx_mailbox_csr.sv
// Module: debug data exchange CSR. Core reads return the word loaded by
// the debug module. Core writes are forwarded to the debug module as a
// capture event. Assumes a single core CSR access per cycle, and that
// privilege checks are done upstream.
module dbgx_mailbox_csr #(
    parameter int          DATA_W       = 32,
    parameter int          ADDR_W       = 12,
    parameter logic [11:0] MAILBOX_ADDR = 12'h7B4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csr_valid,
    input  logic                csr_write,
    input  logic [ADDR_W-1:0]   csr_addr,
    input  logic [DATA_W-1:0]   csr_wdata,
    output logic [DATA_W-1:0]   csr_rdata,
    input  logic                dm_wr_en,
    input  logic [DATA_W-1:0]   dm_wr_data,
    input  logic                dm_clear,
    output logic                dm_data_valid,
    output logic [DATA_W-1:0]   dm_data
);
    dbgx_pkg::acc_kind_e kind;
    logic                read_hit;
    logic                write_hit;

    dbgx_addr_match #(
        .ADDR_W    (ADDR_W),
        .MATCH_ADDR(MAILBOX_ADDR)
    ) u_match (
        .req_valid(csr_valid),
        .req_write(csr_write),
        .req_addr (csr_addr),
        .kind     (kind)
    );

    // Split the decoded access into its read and write hits.
    always_comb begin
        read_hit  = (kind == dbgx_pkg::ACC_READ);
        write_hit = (kind == dbgx_pkg::ACC_WRITE);
    end

    dbgx_value_reg #(.DATA_W(DATA_W)) u_value (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (dm_wr_en),
        .load_data(dm_wr_data),
        .read_hit (read_hit),
        .rdata    (csr_rdata)
    );

    dbgx_capture #(.DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .write_hit (write_hit),
        .write_data(csr_wdata),
        .clear     (dm_clear),
        .strobe    (dm_data_valid),
        .word      (dm_data)
    );
endmodule

// File: rtl/dbgx_mailbox_csr_checker.sv
// Checker: temporal properties of the debug mailbox CSR, bound to the top.
module dbgx_mailbox_csr_checker #(
    parameter int          DATA_W       = 32,
    parameter int          ADDR_W       = 12,
    parameter logic [11:0] MAILBOX_ADDR = 12'h7B4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                csr_valid,
    input logic                csr_write,
    input logic [ADDR_W-1:0]   csr_addr,
    input logic [DATA_W-1:0]   csr_wdata,
    input logic [DATA_W-1:0]   csr_rdata,
    input logic                dm_clear,
    input logic                dm_data_valid,
    input logic [DATA_W-1:0]   dm_data
);
    localparam logic [ADDR_W-1:0] MB = ADDR_W'(MAILBOX_ADDR);

    logic wr_hit_in;
    logic miss_in;
    assign wr_hit_in = csr_valid && csr_write && (csr_addr == MB);
    assign miss_in   = !csr_valid || (csr_addr != MB);

    // R3: each core write produces a strobe that carries its data.
    a_r3_strobe_carries_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit_in |=> (dm_data_valid && dm_data == $past(csr_wdata)));

    // R3, R8: without a write hit there is no strobe.
    a_r3_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit_in |=> !dm_data_valid);

    // R6: a clear with no write hit zeroes the captured word.
    a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_clear && !wr_hit_in) |=> (dm_data == '0));

    // R7: with neither a write hit nor a clear, the captured word holds.
    a_r7_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!dm_clear && !wr_hit_in) |=> $stable(dm_data));

    // R8: a miss or idle cycle leaves the read result alone.
    a_r8_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        miss_in |=> $stable(csr_rdata));
endmodule

bind dbgx_mailbox_csr dbgx_mailbox_csr_checker #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .MAILBOX_ADDR(MAILBOX_ADDR)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_valid    (csr_valid),
    .csr_write    (csr_write),
    .csr_addr     (csr_addr),
    .csr_wdata    (csr_wdata),
    .csr_rdata    (csr_rdata),
    .dm_clear     (dm_clear),
    .dm_data_valid(dm_data_valid),
    .dm_data      (dm_data)
);

// File: tb/dbgx_mailbox_csr_test.sv
module dbgx_mailbox_csr_test;
    localparam int          DW = 32;
    localparam int          AW = 12;
    localparam logic [11:0] MB = 12'h7B4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_valid = 1'b0, csr_write = 1'b0;
    logic [AW-1:0] csr_addr = '0;
    logic [DW-1:0] csr_wdata = '0;
    logic [DW-1:0] csr_rdata;
    logic          dm_wr_en = 1'b0, dm_clear = 1'b0;
    logic [DW-1:0] dm_wr_data = '0;
    logic          dm_data_valid;
    logic [DW-1:0] dm_data;

    int vectors = 0;
    int errors  = 0;

    // Reference state, derived from the requirements.
    logic [DW-1:0] m_val = '0, m_rdata = '0, m_cap = '0;
    logic          m_stb = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dbgx_mailbox_csr #(.DATA_W(DW), .ADDR_W(AW), .MAILBOX_ADDR(MB)) uut (
        .clk(clk), .rst_n(rst_n),
        .csr_valid(csr_valid), .csr_write(csr_write), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .dm_wr_en(dm_wr_en), .dm_wr_data(dm_wr_data), .dm_clear(dm_clear),
        .dm_data_valid(dm_data_valid), .dm_data(dm_data)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update the model, compare at the next negedge.
    task automatic cycle(input logic v, input logic w, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input logic dmw,
                         input logic [DW-1:0] dmd, input logic clr, input string req);
        logic hit;
        csr_valid = v; csr_write = w; csr_addr = a; csr_wdata = wd;
        dm_wr_en = dmw; dm_wr_data = dmd; dm_clear = clr;
        hit = v && (a == MB);
        if (hit && !w) m_rdata = m_val;
        if (dmw)       m_val   = dmd;
        m_stb = hit && w;
        if (hit && w)  m_cap = wd;
        else if (clr)  m_cap = '0;
        @(negedge clk);
        check({req, " rdata"}, csr_rdata, m_rdata);
        check({req, " strobe"}, {31'd0, dm_data_valid}, {31'd0, m_stb});
        check({req, " dm_data"}, dm_data, m_cap);
    endtask

    task automatic idle(input string req);
        cycle(1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state.
        check("R9 rdata", csr_rdata, '0);
        check("R9 strobe", {31'd0, dm_data_valid}, '0);
        check("R9 dm_data", dm_data, '0);
        rst_n = 1'b1;

        // R2, R1: load a value then read it back.
        cycle(1'b0, 1'b0, '0, '0, 1'b1, 32'hCAFE_0001, 1'b0, "R2 load");
        cycle(1'b1, 1'b0, MB, '0, 1'b0, '0, 1'b0, "R1 read");
        check("R1 read value", csr_rdata, 32'hCAFE_0001);

        // R8: read sweep over the full address space.
        for (int a = 0; a < (1 << AW); a++) begin
            cycle(1'b1, 1'b0, AW'(a), '0, 1'b1, 32'(a) * 32'h9E37_79B9, 1'b0, "R8 R1 read sweep");
        end
        // R8, R3, R7: write sweep over the full address space.
        for (int a = 0; a < (1 << AW); a++) begin
            cycle(1'b1, 1'b1, AW'(a), 32'(a) ^ 32'h5A5A_0000, 1'b0, '0, 1'b0, "R8 R3 write sweep");
        end
        idle("R7 hold");
        check("R7 captured word", dm_data, 32'h5A5A_07B4);

        // R4: a core write does not change the readable value.
        cycle(1'b0, 1'b0, '0, '0, 1'b1, 32'h1234_5678, 1'b0, "R2 load");
        cycle(1'b1, 1'b1, MB, 32'hFFFF_FFFF, 1'b0, '0, 1'b0, "R4 write");
        cycle(1'b1, 1'b0, MB, '0, 1'b0, '0, 1'b0, "R4 read");
        check("R4 read after write", csr_rdata, 32'h1234_5678);

        // R3: back-to-back writes, then the strobe drops.
        cycle(1'b1, 1'b1, MB, 32'hA, 1'b0, '0, 1'b0, "R3 b2b 1");
        cycle(1'b1, 1'b1, MB, 32'hB, 1'b0, '0, 1'b0, "R3 b2b 2");
        idle("R3 drop");
        check("R3 strobe low", {31'd0, dm_data_valid}, '0);

        // R5: debug load and core write in the same cycle.
        cycle(1'b1, 1'b1, MB, 32'h0BAD_F00D, 1'b1, 32'h600D_0000, 1'b0, "R5 collide");
        check("R5 captured", dm_data, 32'h0BAD_F00D);
        cycle(1'b1, 1'b0, MB, '0, 1'b0, '0, 1'b0, "R5 read");
        check("R5 readable", csr_rdata, 32'h600D_0000);

        // R6: clear alone, then clear colliding with a write.
        cycle(1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b1, "R6 clear");
        check("R6 cleared", dm_data, '0);
        cycle(1'b1, 1'b1, MB, 32'h7777_0001, 1'b0, '0, 1'b1, "R6 write wins");
        check("R6 write wins", dm_data, 32'h7777_0001);
        // R6: a clear on a missed write address still clears.
        cycle(1'b1, 1'b1, MB ^ 12'h001, 32'h1, 1'b0, '0, 1'b1, "R6 R8 clear on miss");

        // R9: mid-run reset.
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 rdata", csr_rdata, '0);
        check("R9 dm_data", dm_data, '0);
        rst_n = 1'b1;
        m_val = '0; m_rdata = '0; m_cap = '0; m_stb = 1'b0;
        cycle(1'b1, 1'b0, MB, '0, 1'b0, '0, 1'b0, "R9 value cleared");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule